// File: doc/BRIEF.md
# Interrupt Status and Mask Unit for an Instrument Bus Interface

This unit gathers single-cycle event pulses from an instrument-bus interface core into two 8-bit status registers and reduces them to one host interrupt. Each status bit has a matching mask bit. An event can raise the interrupt only when its mask bit is set, the global enable is on, and the disable-all control is off. The interrupt appears as a level on one of `NUM_LINES` output lines. A line-select field picks which line carries it.

The host uses a small register bus. A read returns a status register and clears it in the same access. A write at the same address loads the matching mask. Two more write addresses hold the control bits and the line select. Status register 0 also carries two summary bits, one for each register, that show whether any masked event is pending. A software-reset input clears both status registers and leaves the masks, control bits and line select unchanged.

Register map, by `addr_i`:
- Address 0: read returns status 0; write loads mask 0 from `wdata_i[5:0]`.
- Address 1: read returns status 1; write loads mask 1 from `wdata_i[7:0]`.
- Address 2: write only. `wdata_i[0]` is the global enable and `wdata_i[1]` is disable-all.
- Address 3: write only. `wdata_i[3:0]` is the line select.

A read of address 2 or 3 returns zero.

Top module: `irq_status_hub`

## Requirements
- R1: After reset, both status registers, both masks, the control bits and the line select are zero, `irq_o` is all zero, and reads of both status registers return zero.
- R2: A one-cycle pulse on an event input sets its status bit at the next clock edge, and the bit stays set until its register is read or a software reset occurs. Status 0 bits 5..0 take `evt0_i[5:0]`: byte-in, byte-out, end-of-message, serial-poll-active, remote/local change, addressed-state change. Status 1 bits 7..0 take `evt1_i[7:0]`: trigger, handshake error, unrecognised command, address pass-through, device clear, my-address, service request, interface clear.
- R3: A read (`rd_en_i` high) combinationally returns the addressed status in `rdata_o[7:0]` with `rdata_o[15:8]` zero. At the clock edge that ends the read, it clears only that register; the other status register is unaffected.
- R4: An event pulse that arrives in the same cycle as a clearing read of its register is kept: the read returns the old value and the next read returns the new bit.
- R5: Status 0 bit 7 is the OR of status 0 bits 5..0 ANDed with mask 0. Status 0 bit 6 is the OR of status 1 ANDed with mask 1.
- R6: The interrupt is asserted only when some status bit and its mask bit are both set, the global enable is 1, and disable-all is 0.
- R7: Disable-all forces `irq_o` to zero but does not alter either status register. Clearing it restores the interrupt for events still pending.
- R8: When asserted, the interrupt drives only `irq_o[sel]`, where `sel` (0..15) is the line-select value; `irq_o` is never more than one-hot.
- R9: `irq_o` is a level that stays high while an enabled, masked status bit remains set, and it drops in the cycle after the last such bit is cleared by a read.
- R10: A one-cycle pulse on `soft_rst_i` clears both status registers at the next edge and keeps the masks, control bits and line select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Clears both status registers |
| evt0_i | input | 6 | Event pulses for status 0 bits 5..0 |
| evt1_i | input | 8 | Event pulses for status 1 bits 7..0 |
| rd_en_i | input | 1 | Read strobe; clears the addressed status register |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 16 | Read data, upper byte zero |
| irq_o | output | 16 | One-hot interrupt lines |

## Verification
The interrupt is combinational from the status flops, so a status bit that is lost, stuck or cleared at the wrong time shows on `irq_o` in the first cycle after the event or read. A wrong summary bit, or a read that clears too much, shows in the very next read of status 0 or status 1. A decoder fault shows as the wrong line, or as more than one line, as soon as the line select is rewritten while an event is pending. A disable-all or software reset that disturbs the wrong state shows when the control bit is released: either the interrupt fails to return, or the masks no longer let a new event through.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    // Status register geometry
    localparam int STAT_W = 8;           // bits per status register
    localparam int EV0_W  = STAT_W - 2;  // event bits in status 0 (below the two summary bits)

    // Register addresses
    localparam int A_ST0 = 0;
    localparam int A_ST1 = 1;
    localparam int A_CTL = 2;
    localparam int A_SEL = 3;

    // Control register bit positions
    localparam int CTL_GE  = 0;
    localparam int CTL_DAI = 1;
endpackage

// File: rtl/irq_evt_bank.sv
// Clear-on-read event latch bank: set wins over a coincident read-clear.
module irq_evt_bank #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         soft_clr_i,
    input  logic         rd_clr_i,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_d, stat_q;

    always_comb begin
        if (soft_clr_i) begin
            stat_d = '0;
        end else begin
            stat_d = (stat_q & ~{W{rd_clr_i}}) | evt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q <= '0;
        else         stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irq_line_router.sv
// Routes one interrupt request onto one of N lines by a binary select.
module irq_line_router #(
    parameter int N     = 16,
    parameter int SEL_W = $clog2(N)
) (
    input  logic             req_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [N-1:0]     line_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign line_o[i] = req_i && (sel_i == SEL_W'(i));
    end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int BUS_W     = 16,
    parameter int ADDR_W    = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 soft_rst_i,
    input  logic [EV0_W-1:0]     evt0_i,
    input  logic [STAT_W-1:0]    evt1_i,
    input  logic                 rd_en_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [STAT_W-1:0]    wdata_i,
    output logic [BUS_W-1:0]     rdata_o,
    output logic [NUM_LINES-1:0] irq_o
);
    localparam int SEL_W = $clog2(NUM_LINES);

    typedef struct packed {
        logic              ge;
        logic              dai;
        logic [EV0_W-1:0]  m0;
        logic [STAT_W-1:0] m1;
        logic [SEL_W-1:0]  sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [EV0_W-1:0]  st0_w;
    logic [STAT_W-1:0] st1_w;
    logic              rd0_w, rd1_w;
    logic              int0_w, int1_w;
    logic              gate_w, req_w;
    logic              unused_wdata;

    assign rd0_w = rd_en_i && (addr_i == ADDR_W'(A_ST0));
    assign rd1_w = rd_en_i && (addr_i == ADDR_W'(A_ST1));
    assign unused_wdata = ^wdata_i;

    irq_evt_bank #(.W(EV0_W)) u_bank0 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_clr_i (soft_rst_i),
        .rd_clr_i   (rd0_w),
        .evt_i      (evt0_i),
        .stat_o     (st0_w)
    );

    irq_evt_bank #(.W(STAT_W)) u_bank1 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_clr_i (soft_rst_i),
        .rd_clr_i   (rd1_w),
        .evt_i      (evt1_i),
        .stat_o     (st1_w)
    );

    // Control register next state
    always_comb begin
        ctl_d = ctl_q;
        if (wr_en_i) begin
            case (addr_i)
                ADDR_W'(A_ST0): ctl_d.m0 = wdata_i[EV0_W-1:0];
                ADDR_W'(A_ST1): ctl_d.m1 = wdata_i;
                ADDR_W'(A_CTL): begin
                    ctl_d.ge  = wdata_i[CTL_GE];
                    ctl_d.dai = wdata_i[CTL_DAI];
                end
                ADDR_W'(A_SEL): ctl_d.sel = wdata_i[SEL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    // Summary bits and gating
    assign int0_w = |(st0_w & ctl_q.m0);
    assign int1_w = |(st1_w & ctl_q.m1);
    assign gate_w = ctl_q.ge && !ctl_q.dai;
    assign req_w  = gate_w && (int0_w || int1_w);

    // Read mux
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (addr_i)
                ADDR_W'(A_ST0): rdata_o[STAT_W-1:0] = {int0_w, int1_w, st0_w};
                ADDR_W'(A_ST1): rdata_o[STAT_W-1:0] = st1_w;
                default: ;
            endcase
        end
    end

    irq_line_router #(.N(NUM_LINES), .SEL_W(SEL_W)) u_router (
        .req_i  (req_w),
        .sel_i  (ctl_q.sel),
        .line_o (irq_o)
    );
endmodule

// File: rtl/irq_status_hub_chk.sv
module irq_status_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int BUS_W     = 16,
    parameter int ADDR_W    = 2
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 soft_rst_i,
    input logic                 rd_en_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [BUS_W-1:0]     rdata_o,
    input logic [STAT_W-1:0]    evt1_i,
    input logic [EV0_W-1:0]     st0,
    input logic [STAT_W-1:0]    st1,
    input logic                 gate_ok,
    input logic [NUM_LINES-1:0] irq_o
);
    AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |-> (rdata_o[BUS_W-1:STAT_W] == '0)); // R3

    AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == ADDR_W'(A_ST1) && !soft_rst_i && evt1_i == '0) |=> (st1 == '0)); // R3

    AST_HOLD_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!soft_rst_i && !(rd_en_i && addr_i == ADDR_W'(A_ST0))) |=> ((st0 & $past(st0)) == $past(st0))); // R2

    AST_EVT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!soft_rst_i && evt1_i != '0) |=> ((st1 & $past(evt1_i)) == $past(evt1_i))); // R4

    AST_GATE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gate_ok |-> (irq_o == '0)); // R6

    AST_LINES_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(irq_o)); // R8

    AST_IRQ_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st0 == '0 && st1 == '0) |-> (irq_o == '0)); // R9

    AST_SOFT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (st0 == '0 && st1 == '0)); // R10
endmodule

bind irq_status_hub irq_status_hub_chk #(
    .NUM_LINES (NUM_LINES),
    .BUS_W     (BUS_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .evt1_i     (evt1_i),
    .st0        (st0_w),
    .st1        (st1_w),
    .gate_ok    (gate_w),
    .irq_o      (irq_o)
);

// File: tb/irq_status_hub_bench.sv
`timescale 1ns/1ps
module irq_status_hub_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [5:0]  evt0 = '0;
    logic [7:0]  evt1 = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [15:0] rdata;
    logic [15:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    irq_status_hub u_irq_status_hub (
        .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
        .evt0_i(evt0), .evt1_i(evt1), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // e0, e1, m0, m1, ge, dai, sel, expected irq, expected status0 read, expected status1 read
    typedef struct packed {
        logic [5:0]  e0;
        logic [7:0]  e1;
        logic [5:0]  m0;
        logic [7:0]  m1;
        logic        ge;
        logic        dai;
        logic [3:0]  sel;
        logic [15:0] x_irq;
        logic [7:0]  x_r0;
        logic [7:0]  x_r1;
    } vec_t;

    localparam int NV = 8;
    localparam logic [65:0] VECS [NV] = '{
        {6'h20, 8'h00, 6'h20, 8'h00, 1'b1, 1'b0, 4'd0,  16'h0001, 8'hA0, 8'h00},
        {6'h00, 8'h80, 6'h00, 8'h80, 1'b1, 1'b0, 4'd15, 16'h8000, 8'h40, 8'h80},
        {6'h01, 8'h01, 6'h02, 8'h02, 1'b1, 1'b0, 4'd5,  16'h0000, 8'h01, 8'h01},
        {6'h3F, 8'hFF, 6'h3F, 8'hFF, 1'b0, 1'b0, 4'd3,  16'h0000, 8'hFF, 8'hFF},
        {6'h10, 8'h20, 6'h3F, 8'hFF, 1'b1, 1'b1, 4'd7,  16'h0000, 8'hD0, 8'h20},
        {6'h0C, 8'h00, 6'h04, 8'h00, 1'b1, 1'b0, 4'd9,  16'h0200, 8'h8C, 8'h00},
        {6'h00, 8'h05, 6'h00, 8'h04, 1'b1, 1'b0, 4'd12, 16'h1000, 8'h40, 8'h05},
        {6'h02, 8'h40, 6'h02, 8'h40, 1'b1, 1'b0, 4'd1,  16'h0002, 8'hC2, 8'h40}
    };

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] e0, input logic [7:0] e1);
        evt0 = e0; evt1 = e1;
        @(negedge clk);
        evt0 = '0; evt1 = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "irq after reset", irq, 16'h0000);
        bus_rd(2'd0, v); chk("R1", "status0 after reset", v, 16'h0000);
        bus_rd(2'd1, v); chk("R1", "status1 after reset", v, 16'h0000);

        // Table walk: R2 R3 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            vec_t t;
            t = vec_t'(VECS[i]);
            bus_wr(2'd0, {2'b00, t.m0});
            bus_wr(2'd1, t.m1);
            bus_wr(2'd2, {6'b0, t.dai, t.ge});
            bus_wr(2'd3, {4'b0, t.sel});
            pulse(t.e0, t.e1);
            chk("R6", $sformatf("vec %0d irq", i), irq, t.x_irq);
            bus_rd(2'd0, v); chk("R5", $sformatf("vec %0d status0", i), v, {8'h00, t.x_r0});
            bus_rd(2'd1, v); chk("R3", $sformatf("vec %0d status1", i), v, {8'h00, t.x_r1});
            chk("R9", $sformatf("vec %0d irq after reads", i), irq, 16'h0000);
        end

        // R2 / R9: hold while pending; R3: other register unaffected
        bus_wr(2'd0, 8'h01); bus_wr(2'd1, 8'h00); bus_wr(2'd2, 8'h01); bus_wr(2'd3, 8'h02);
        pulse(6'h01, 8'h00);
        repeat (5) @(negedge clk);
        chk("R2", "irq held while bit pending", irq, 16'h0004);
        bus_rd(2'd1, v); chk("R3", "status1 empty", v, 16'h0000);
        chk("R3", "irq kept after other read", irq, 16'h0004);
        bus_rd(2'd0, v); chk("R2", "status0 kept bit", v, 16'h0081);
        chk("R9", "irq drops after clearing read", irq, 16'h0000);
        bus_rd(2'd0, v); chk("R3", "status0 cleared", v, 16'h0000);

        // R4: event coincident with clearing read
        pulse(6'h00, 8'h01);
        evt1 = 8'h08; rd_en = 1'b1; addr = 2'd1;
        #1 v = rdata;
        @(negedge clk);
        evt1 = '0; rd_en = 1'b0;
        chk("R4", "read returns old value", v, 16'h0001);
        bus_rd(2'd1, v); chk("R4", "coincident event kept", v, 16'h0008);
        bus_rd(2'd1, v); chk("R3", "status1 cleared", v, 16'h0000);

        // R7: disable-all keeps status
        bus_wr(2'd0, 8'h3F); bus_wr(2'd3, 8'h00); bus_wr(2'd2, 8'h03);
        pulse(6'h08, 8'h00);
        chk("R7", "irq suppressed", irq, 16'h0000);
        bus_wr(2'd2, 8'h01);
        chk("R7", "irq returns after release", irq, 16'h0001);
        bus_rd(2'd0, v); chk("R7", "status intact", v, 16'h0088);

        // R10: software reset
        bus_wr(2'd1, 8'hFF);
        pulse(6'h3F, 8'hFF);
        chk("R10", "irq before soft reset", irq, 16'h0001);
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        chk("R10", "irq after soft reset", irq, 16'h0000);
        bus_rd(2'd0, v); chk("R10", "status0 cleared", v, 16'h0000);
        bus_rd(2'd1, v); chk("R10", "status1 cleared", v, 16'h0000);
        pulse(6'h00, 8'h02);
        chk("R10", "masks kept", irq, 16'h0001);
        bus_rd(2'd1, v); chk("R10", "new event read", v, 16'h0002);

        // R8: line select sweep
        pulse(6'h01, 8'h00);
        for (int s = 0; s < 16; s++) begin
            bus_wr(2'd3, 8'(s));
            chk("R8", $sformatf("line %0d", s), irq, 16'h0001 << s);
        end
        bus_rd(2'd0, v); chk("R8", "sweep status0", v, 16'h0081);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule